// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

A purely combinational arithmetic logic unit for the execute stage of a small RISC integer pipeline. Two operand words and a 3-bit operation selector go in. One result word comes out, together with three flags: zero, signed overflow and carry-out. Bitwise AND and OR come from a logic slice. Addition, subtraction and the signed set-less-than compare all share a single adder. For subtraction the second operand is inverted and the carry-in is forced high.

The set-less-than decision takes the sign of the difference and XORs it with the overflow of that subtraction, so the compare stays correct even when the difference wraps. An equality test for branches works by subtracting and reading the zero flag. The adder is built from lookahead groups whose carries ripple from group to group. Overflow is only reported; the block takes no trap action.

Top module: `int_alu`

## Requirements
- R1: Selector 3'b000 returns the bitwise AND of a_i and b_i.
- R2: Selector 3'b001 returns the bitwise OR of a_i and b_i.
- R3: Selector 3'b010 returns (a_i + b_i) modulo 2^WIDTH.
- R4: Selector 3'b110 returns (a_i - b_i) modulo 2^WIDTH. It is formed as a_i plus the inverse of b_i plus a carry-in of 1.
- R5: Selector 3'b111 returns 1 in bit 0 and zeros in all other bits when a_i < b_i as two's complement numbers, and all zeros otherwise. This holds even when a_i - b_i overflows.
- R6: zero_o is 1 exactly when result_o is all zeros, for every selector value.
- R7: For selector 3'b010, overflow_o is 1 exactly when both operands have the same sign and the sum has the opposite sign.
- R8: For selector 3'b110, overflow_o is 1 exactly in two cases: a non-negative a_i minus a negative b_i gives a negative result, or a negative a_i minus a non-negative b_i gives a non-negative result.
- R9: carry_o is the carry out of the top adder bit for selectors 3'b010 and 3'b110; for subtraction this is 1 when a_i >= b_i unsigned. carry_o is 0 for 3'b000, 3'b001 and 3'b111. overflow_o is also 0 for those three selectors.
- R10: Selector values 3'b011, 3'b100 and 3'b101 give result_o = 0, overflow_o = 0 and carry_o = 0, so zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation selector |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top adder bit |

## Verification
The hardest case to reach is a set-less-than whose internal subtraction overflows. Only there does the sign of the difference give the wrong answer, and random operands seldom land on it. The stimulus places operands on purpose at the extremes of the signed range: the most negative value against positive values, and the most positive value against negative values. It also walks carries through group boundaries with all-ones and single-bit patterns. A long pseudo-random sweep then covers every selector, including the unused codes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;
endpackage

// File: rtl/int_alu_cla_adder.sv
module int_alu_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int NGRP = WIDTH / GROUP;

  logic [NGRP:0]   grp_c;
  logic [NGRP-1:0] msb_cin;

  assign grp_c[0] = cin_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : gen_grp
    localparam int BASE = gi * GROUP;
    logic [GROUP-1:0] gen, prop;
    logic [GROUP:0]   lc;
    logic             grp_g, grp_p;

    assign gen  = a_i[BASE +: GROUP] & b_i[BASE +: GROUP];
    assign prop = a_i[BASE +: GROUP] ^ b_i[BASE +: GROUP];

    always_comb begin
      lc[0] = grp_c[gi];
      for (int k = 0; k < GROUP; k++) lc[k+1] = gen[k] | (prop[k] & lc[k]);
    end

    // group generate/propagate for the inter-group carry
    always_comb begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int k = 0; k < GROUP; k++) begin
        grp_g = gen[k] | (prop[k] & grp_g);
        grp_p = grp_p & prop[k];
      end
    end

    assign grp_c[gi+1]        = grp_g | (grp_p & grp_c[gi]);
    assign sum_o[BASE +: GROUP] = prop ^ lc[GROUP-1:0];
    assign msb_cin[gi]        = lc[GROUP-1];
  end

  assign cout_o = grp_c[NGRP];
  assign ovf_o  = cout_o ^ msb_cin[NGRP-1];

  always_comb begin
    AST_SUM_ARITH: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})); // R3
    AST_OVF_SIGN: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]))); // R7
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    assign res_o[i] = sel_or_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             diff_msb_i,
  input  logic             diff_ovf_i,
  output logic             zero_o,
  output logic             less_o
);
  assign zero_o = ~|result_i;
  // sign corrected by overflow keeps signed compare exact when the difference wraps
  assign less_o = diff_msb_i ^ diff_ovf_i;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  logic             sub_mode, arith;
  logic [WIDTH-1:0] b_eff, sum, logic_res;
  logic             add_cout, add_ovf, less;

  assign sub_mode = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign arith    = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign b_eff    = sub_mode ? ~b_i : b_i;

  int_alu_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) adder_i (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (sub_mode),
    .sum_o  (sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  int_alu_logic #(.WIDTH(WIDTH)) logic_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_or_i (op_i[0]),
    .res_o    (logic_res)
  );

  int_alu_flags #(.WIDTH(WIDTH)) flags_i (
    .result_i   (result_o),
    .diff_msb_i (sum[WIDTH-1]),
    .diff_ovf_i (add_ovf),
    .zero_o     (zero_o),
    .less_o     (less)
  );

  always_comb begin
    unique case (op_i)
      OP_AND, OP_OR:   result_o = logic_res;
      OP_ADD, OP_SUB:  result_o = sum;
      OP_SLT:          result_o = {{(WIDTH-1){1'b0}}, less};
      default:         result_o = '0;
    endcase
  end

  assign overflow_o = arith & add_ovf;
  assign carry_o    = arith & add_cout;

  always_comb begin
    if (op_i == OP_SLT) begin
      AST_SLT_UPPER: assert (result_o[WIDTH-1:1] == '0); // R5
    end
    if (!arith) begin
      AST_QUIET_FLAGS: assert (!overflow_o && !carry_o); // R9
    end
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      AST_UNUSED_ZERO: assert (result_o == '0 && zero_o); // R10
    end
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R6
  end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a, b, res;
  logic [2:0]  op;
  logic        zf, of, cf;
  int n_cmp = 0, n_bad = 0;
  bit  done = 0;

  int_alu #(.WIDTH(32), .GROUP(4)) dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zf), .overflow_o(of), .carry_o(cf)
  );

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3/R7/R9";
      3'b110: return "R4/R8/R9";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [2:0] ov);
    logic [32:0] wide;
    longint sa, sb, sr;
    logic [31:0] e_res;
    logic e_of, e_cf, e_zf;
    @(posedge clk);
    a = av; b = bv; op = ov;
    sa = longint'($signed(av));
    sb = longint'($signed(bv));
    e_res = '0; e_of = 0; e_cf = 0;
    case (ov)
      3'b000: e_res = av & bv;
      3'b001: e_res = av | bv;
      3'b010: begin
        wide = {1'b0, av} + {1'b0, bv};
        e_res = wide[31:0]; e_cf = wide[32];
        sr = sa + sb;
        e_of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'b110: begin
        wide = {1'b0, av} + {1'b0, ~bv} + 33'd1;
        e_res = wide[31:0]; e_cf = wide[32];
        sr = sa - sb;
        e_of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'b111: e_res = (sa < sb) ? 32'd1 : 32'd0;
      default: e_res = '0;
    endcase
    e_zf = (e_res == 0); // R6
    @(negedge clk);
    n_cmp++;
    if (res !== e_res || zf !== e_zf || of !== e_of || cf !== e_cf) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
               req_of(ov), ov, av, bv, res, zf, of, cf, e_res, e_zf, e_of, e_cf);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr_a, lfsr_b;
    logic [2:0]  ops [8];
    a = '0; b = '0; op = '0;
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110;
    ops[4] = 3'b111; ops[5] = 3'b011; ops[6] = 3'b100; ops[7] = 3'b101;
    // initial state: all zeros with AND gives zero flag (R6)
    apply(32'h0, 32'h0, 3'b000);
    // R1, R2
    apply(32'hF0F0_1234, 32'hFF00_FF0F, 3'b000);
    apply(32'hF0F0_1234, 32'h0F0F_0000, 3'b001);
    apply(32'h0000_0000, 32'h0000_0000, 3'b001);
    // R3, R7, R9: carry through all groups, positive and negative overflow
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h8000_0000, 32'h8000_0000, 3'b010);
    apply(32'h0000_000F, 32'h0000_0001, 3'b010);
    // R4, R8, R9: equal operands give zero, borrow, both overflow directions
    apply(32'h1234_5678, 32'h1234_5678, 3'b110);
    apply(32'h0000_0001, 32'h0000_0002, 3'b110);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    apply(32'h8000_0000, 32'h0000_0001, 3'b110);
    apply(32'h0000_0000, 32'h8000_0000, 3'b110);
    // R5: signed compare including overflowing differences
    apply(32'h8000_0000, 32'h0000_0001, 3'b111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
    apply(32'h0000_0005, 32'h0000_0005, 3'b111);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    // R10: unused codes
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b100);
    apply(32'h8000_0000, 32'h8000_0000, 3'b101);
    // pseudo-random sweep over all codes
    lfsr_a = 32'hACE1_1357;
    lfsr_b = 32'h1F2E_3D4C;
    for (int i = 0; i < 4000; i++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      if (i % 5 == 0) apply(lfsr_a ^ 32'h8000_0000, lfsr_b, ops[i % 8]);
      else            apply(lfsr_a, lfsr_b, ops[i % 8]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule